// File: doc/BRIEF.md
# Cartridge ROM Bank Switch Controller

This block maps a small cartridge ROM window on a retro host's cartridge port onto one bank of a 512 KB parallel flash that is only ever read. The flash is split into four 128 KB regions. Two static switches pick the region, and each region holds sixteen 8 KB banks. A 4-bit bank register picks the bank. The host changes banks by writing anywhere inside the window while the ROM-select and write strobes are low. The low four bits of the host address become the new bank number, and any written data is not used.

The host bus has no clock and its strobes are asynchronous. The block brings every host input into its own clock domain through a multi-stage synchronizer, works out from the synchronized strobes whether the cycle is a read, a write or idle, and drives registered flash control and address lines. After reset, the bank register points at the last bank of the selected region, so the menu program stored there runs first. The flash write-enable is held high at all times, so it never floats and never reaches an active level.

Top module: `cart_bank_switch`

## Requirements
- R1: During a window read, flash_addr equals {region_sw[1:0], bank[3:0], host_addr[12:0]}. region_sw is in bits 18:17, the bank in bits 16:13 and the window offset in bits 12:0.
- R2: Reset (rst high) sets the bank to 15, the last bank of the region, whatever the switch setting. A reset in the middle of operation does the same.
- R3: A window write (host_mem_n=0, host_rom_n=0, host_wr_n=0) loads host_addr[3:0] into the bank register. It loads once, on the cycle the write is first seen. A write held low while the address changes does not load again.
- R4: A write strobe while host_rom_n=1 or host_mem_n=1 leaves the bank unchanged. The bank also holds when no window write takes place.
- R5: flash_ce_n and flash_oe_n are low only during a window read (host_mem_n=0, host_rom_n=0, host_wr_n=1). They are high when idle and during window writes, so host writes never reach the flash.
- R6: flash_we_n is high during reset and at every cycle after it.
- R7: A change of region_sw moves flash_addr[18:17] to the new region and leaves the bank number as it was.
- R8: An input held stable shows at the outputs within SYNC_STAGES+2 clock cycles. A bank load shows on flash_addr within SYNC_STAGES+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host address bus (asynchronous) |
| host_mem_n | input | 1 | Host memory-enable, active low |
| host_rom_n | input | 1 | Cartridge ROM window select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| region_sw | input | 2 | Static region-select switches |
| flash_addr | output | 19 | Flash address, registered |
| flash_ce_n | output | 1 | Flash chip-enable, active low, registered |
| flash_oe_n | output | 1 | Flash output-enable, active low, registered |
| flash_we_n | output | 1 | Flash write-enable, always high |

## Verification
The bench uses the default parameters: two synchronizer stages, a 4-bit bank and a 13-bit window. This makes the sweep exhaustive over every bank in every region: each of the four switch settings is combined with all sixteen bank writes. Each bank is read back at several computed window offsets. Two stages keep the input-to-output latency short, so the bench can also test writes that are gated off, a write held while its address changes, and a reset in the middle of operation.

// File: rtl/cartbank_pkg.sv
package cartbank_pkg;

  // Kind of host access, decoded from the synchronized strobes
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  function automatic acc_kind_t classify_access(logic mem_n, logic rom_n, logic wr_n);
    acc_kind_t k;
    k = ACC_IDLE;
    if (!mem_n && !rom_n) begin
      k = wr_n ? ACC_READ : ACC_WRITE;
    end
    return k;
  endfunction

endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int          WIDTH  = 8,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= INIT;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= INIT;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cb_bank_reg.sv
module cb_bank_reg
  import cartbank_pkg::*;
#(
  parameter int BANK_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  acc_kind_t            acc,
  input  logic [BANK_BITS-1:0] addr_lo,
  output logic [BANK_BITS-1:0] bank
);

  localparam logic [BANK_BITS-1:0] LAST_BANK = '1;

  logic was_write;
  logic load;

  assign load = (acc == ACC_WRITE) && !was_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_write <= 1'b0;
      bank      <= LAST_BANK;
    end else begin
      was_write <= (acc == ACC_WRITE);
      if (load) bank <= addr_lo;
    end
  end

  // R3
  bank_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> bank == $past(addr_lo));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(bank));

  // R3
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

endmodule

// File: rtl/cb_flash_drive.sv
module cb_flash_drive
  import cartbank_pkg::*;
#(
  parameter int SW_BITS   = 2,
  parameter int BANK_BITS = 4,
  parameter int WIN_BITS  = 13,
  localparam int FA_BITS  = SW_BITS + BANK_BITS + WIN_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  acc_kind_t            acc,
  input  logic [SW_BITS-1:0]   sw,
  input  logic [BANK_BITS-1:0] bank,
  input  logic [WIN_BITS-1:0]  win_addr,
  output logic [FA_BITS-1:0]   flash_addr,
  output logic                 flash_ce_n,
  output logic                 flash_oe_n,
  output logic                 flash_we_n
);

  logic rd_now;
  assign rd_now = (acc == ACC_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_addr <= '0;
      flash_ce_n <= 1'b1;
      flash_oe_n <= 1'b1;
      flash_we_n <= 1'b1;
    end else begin
      flash_addr <= {sw, bank, win_addr};
      flash_ce_n <= !rd_now;
      flash_oe_n <= !rd_now;
      flash_we_n <= 1'b1;
    end
  end

  // R5
  no_write_reach_chk: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WRITE) |=> (flash_ce_n && flash_oe_n));

  // R5
  ce_oe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    flash_ce_n == flash_oe_n);

  // R6
  we_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flash_we_n) |-> flash_we_n);

endmodule

// File: rtl/cart_bank_switch.sv
module cart_bank_switch
  import cartbank_pkg::*;
#(
  parameter int HOST_AW     = 16,
  parameter int SW_BITS     = 2,
  parameter int BANK_BITS   = 4,
  parameter int WIN_BITS    = 13,
  parameter int SYNC_STAGES = 2,
  localparam int FA_BITS    = SW_BITS + BANK_BITS + WIN_BITS,
  localparam int SYNC_W     = HOST_AW + 3 + SW_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_mem_n,
  input  logic               host_rom_n,
  input  logic               host_wr_n,
  input  logic [SW_BITS-1:0] region_sw,
  output logic [FA_BITS-1:0] flash_addr,
  output logic               flash_ce_n,
  output logic               flash_oe_n,
  output logic               flash_we_n
);

  localparam logic [SYNC_W-1:0] SYNC_INIT = {{HOST_AW{1'b0}}, 3'b111, {SW_BITS{1'b0}}};

  logic [SYNC_W-1:0]  raw_in, syn_in;
  logic [HOST_AW-1:0] s_addr;
  logic               s_mem_n, s_rom_n, s_wr_n;
  logic [SW_BITS-1:0] s_sw;
  acc_kind_t          acc;
  logic [BANK_BITS-1:0] bank;

  assign raw_in = {host_addr, host_mem_n, host_rom_n, host_wr_n, region_sw};

  cb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  assign {s_addr, s_mem_n, s_rom_n, s_wr_n, s_sw} = syn_in;
  assign acc = classify_access(s_mem_n, s_rom_n, s_wr_n);

  cb_bank_reg #(.BANK_BITS(BANK_BITS)) bank_i (
    .clk(clk), .rst(rst), .acc(acc),
    .addr_lo(s_addr[BANK_BITS-1:0]), .bank(bank)
  );

  cb_flash_drive #(.SW_BITS(SW_BITS), .BANK_BITS(BANK_BITS), .WIN_BITS(WIN_BITS)) drive_i (
    .clk(clk), .rst(rst), .acc(acc), .sw(s_sw), .bank(bank),
    .win_addr(s_addr[WIN_BITS-1:0]),
    .flash_addr(flash_addr), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
  );

endmodule

// File: tb/cart_bank_switch_tb.sv
module cart_bank_switch_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] host_addr;
  logic        host_mem_n, host_rom_n, host_wr_n;
  logic [1:0]  region_sw;
  logic [18:0] flash_addr;
  logic        flash_ce_n, flash_oe_n, flash_we_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cart_bank_switch dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_mem_n(host_mem_n),
    .host_rom_n(host_rom_n), .host_wr_n(host_wr_n), .region_sw(region_sw),
    .flash_addr(flash_addr), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Settle time: SYNC_STAGES + 2 = 4 cycles (R8)
  task automatic drive(logic [15:0] a, logic m, logic r, logic w);
    host_addr = a; host_mem_n = m; host_rom_n = r; host_wr_n = w;
    cyc(4);
  endtask

  task automatic idle();
    drive(16'h0000, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic bank_write(logic [3:0] b);
    drive({12'h600, b}, 1'b0, 1'b0, 1'b0);
    chk("R5 write gated", {30'd0, flash_ce_n, flash_oe_n}, 32'd3);
    idle();
  endtask

  task automatic read_chk(logic [1:0] sw, logic [3:0] b, logic [12:0] off, string req);
    drive({3'b011, off}, 1'b0, 1'b0, 1'b1);
    chk(req, {13'd0, flash_addr}, {13'd0, sw, b, off});
    chk("R5 read enables", {30'd0, flash_ce_n, flash_oe_n}, 32'd0);
    chk("R6 we high", {31'd0, flash_we_n}, 32'd1);
  endtask

  initial begin
    rst = 1'b1; region_sw = 2'd2;
    host_addr = '0; host_mem_n = 1'b1; host_rom_n = 1'b1; host_wr_n = 1'b1;
    cyc(2);
    chk("R6 we high in reset", {31'd0, flash_we_n}, 32'd1);
    cyc(3);
    rst = 1'b0;
    cyc(4);
    chk("R2 reset bank", {28'd0, flash_addr[16:13]}, 32'd15);
    chk("R2 reset region", {30'd0, flash_addr[18:17]}, 32'd2);
    chk("R5 idle enables", {30'd0, flash_ce_n, flash_oe_n}, 32'd3);
    chk("R6 we high", {31'd0, flash_we_n}, 32'd1);
    read_chk(2'd2, 4'd15, 13'h0ABC, "R2 reset read");

    // Exhaustive region x bank sweep
    for (int s = 0; s < 4; s++) begin
      region_sw = s[1:0];
      cyc(4);
      chk("R7 region bits", {30'd0, flash_addr[18:17]}, s);
      for (int b = 0; b < 16; b++) begin
        bank_write(b[3:0]);
        for (int k = 0; k < 3; k++) begin
          logic [12:0] off;
          off = 13'((b * 613 + k * 2741 + s * 97) & 13'h1FFF);
          read_chk(s[1:0], b[3:0], off, "R1 R3 compose");
        end
      end
      // bank 15 remains; next region switch must keep it (R7)
    end
    region_sw = 2'd1;
    cyc(4);
    read_chk(2'd1, 4'd15, 13'h1FFF, "R7 bank kept");
    read_chk(2'd1, 4'd15, 13'h0000, "R1 offset zero");

    // Writes outside the window are ignored
    bank_write(4'd5);
    drive(16'h6009, 1'b0, 1'b1, 1'b0);
    chk("R5 rom off enables", {30'd0, flash_ce_n, flash_oe_n}, 32'd3);
    idle();
    read_chk(2'd1, 4'd5, 13'h0123, "R4 rom_n high write");
    drive(16'h600C, 1'b1, 1'b0, 1'b0);
    idle();
    read_chk(2'd1, 4'd5, 13'h0456, "R4 mem_n high write");
    idle(); idle();
    read_chk(2'd1, 4'd5, 13'h1456, "R4 hold idle");

    // Held write with changing address loads once
    drive(16'h6003, 1'b0, 1'b0, 1'b0);
    drive(16'h600C, 1'b0, 1'b0, 1'b0);
    idle();
    read_chk(2'd1, 4'd3, 13'h0777, "R3 single load");

    // Latency: new offset visible after SYNC_STAGES+2 cycles (R8)
    host_addr = 16'h6111; host_mem_n = 1'b0; host_rom_n = 1'b0; host_wr_n = 1'b1;
    cyc(4);
    chk("R8 latency", {13'd0, flash_addr}, {13'd0, 2'd1, 4'd3, 13'h0111});

    // Mid-run reset
    bank_write(4'd7);
    rst = 1'b1; cyc(2); rst = 1'b0;
    cyc(4);
    read_chk(2'd1, 4'd15, 13'h0222, "R2 mid-run reset");

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule